// File: doc/BRIEF.md
# Line-Gap Refresh SDRAM Line Writer

This block takes a stream of processed 8-bit pixel lines and stores them in one SDRAM of a ping-pong pair. Each line is written as a single full-page burst into its own row of one fixed bank. The controller never uses a refresh timer. After every line it closes the row and issues a fixed number of auto-refresh commands in the blanking gap before the next line arrives. It then opens the next row so that the following line can start without delay.

After reset the controller runs a short power-up sequence: a parameterised wait, a precharge of all banks, two auto-refreshes, and a mode-register load that selects full-page bursts. It then waits for a start pulse. When each line finishes, the address of the last word written is latched and reported to the read side, which uses it to decide when to swap buffers.

All SDRAM pins are driven from registers. A decision taken on a clock edge appears on the pins directly after that edge.

Top module: `sdram_line_writer`

## Requirements
- R1: While reset is low, and for the first INIT_WAIT-1 edges after it is released, the command pins show NOP, the address is 0, dq output enable is low and last_valid_o is low. Command encoding is {cs_n, ras_n, cas_n, we_n}: NOP=0111, ACTIVE=0011, WRITE=0100, BURST STOP=0110, PRECHARGE=0010, REFRESH=0001, MODE LOAD=0000.
- R2: Edge INIT_WAIT issues PRECHARGE with address bit 10 set (all banks) and bank 0. T_RP edges later comes REFRESH, then a second REFRESH T_RFC edges after that. T_RFC edges after the second REFRESH comes MODE LOAD with address bits [2:0]=111 (full page), bit 3=0 (sequential) and bits [6:4]=CAS_LAT, bank 0.
- R3: start_i is ignored until T_MRD edges after MODE LOAD. The first start sampled after that issues ACTIVE of row 0 in bank BANK_SEL on the edge that samples it. Any later start has no effect on the pins.
- R4: Once the row is ready, the edge that samples the first line_valid_i issues WRITE with column 0, address bit 10 clear, bank BANK_SEL, and that pixel on dq_o. Each later pixel appears on dq_o with NOP on the edge that samples it. dq output enable is high exactly on these LINE_LEN edges.
- R5: The edge after the LINE_LEN-th pixel issues BURST STOP. The edge after that issues PRECHARGE of bank BANK_SEL with address bit 10 clear.
- R6: Exactly REF_PER_GAP REFRESH commands follow each line. The first comes T_RP edges after the line's PRECHARGE, and the rest follow at intervals of T_RFC edges.
- R7: T_RFC edges after the last REFRESH, ACTIVE opens the next row. Pixels are legal from T_RCD edges after ACTIVE until the line completes, and a line starting exactly then is accepted.
- R8: The row advances by one per completed line and wraps from ROWS-1 to 0.
- R9: On the BURST STOP edge, last_valid_o pulses for one cycle and last_addr_o becomes {bank, row just written, LINE_LEN-1}. It holds that value until the next line completes.
- R10: On every edge not named above, the pins show NOP with address 0, bank 0 and dq output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts line capture after initialisation |
| line_valid_i | input | 1 | Pixel strobe, high for each pixel of a line |
| pixel_i | input | PIX_W | Pixel data |
| sdram_cs_n_o | output | 1 | Chip select, active low |
| sdram_ras_n_o | output | 1 | Row strobe, active low |
| sdram_cas_n_o | output | 1 | Column strobe, active low |
| sdram_we_n_o | output | 1 | Write enable, active low |
| sdram_ba_o | output | BANK_W | Bank address |
| sdram_addr_o | output | ADDR_W | Row, column or mode address |
| sdram_dq_o | output | PIX_W | Write data |
| sdram_dq_oe_o | output | 1 | Write data output enable |
| last_addr_o | output | BANK_W+log2(ROWS)+log2(LINE_LEN) | Bank, row and column of the last word written |
| last_valid_o | output | 1 | One-cycle pulse when last_addr_o updates |

## Verification
Every pin result registers on the edge that samples its cause, so a pixel sampled on edge f is on dq_o right after edge f. BURST STOP and the last-address pulse are due at f+LINE_LEN, and PRECHARGE one edge later. Each refresh, the next ACTIVE and the earliest legal next pixel are fixed offsets of T_RP, T_RFC and T_RCD from that PRECHARGE. The reference model in the bench turns each stimulus into expected pin values at those edge numbers. It drives inputs and compares every output on the falling edge, so every edge is checked, including the NOP edges between commands. Some line gaps are at the tight minimum, which places the first pixel exactly on the ready edge.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_INIT, ST_IREF, ST_MRS, ST_IDLE, ST_OPEN,
    ST_WRITE, ST_PRE, ST_REF, ST_ACT
  } wr_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_wr_timer.sv
module sdram_wr_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_wr_rowctr.sv
module sdram_wr_rowctr #(
  parameter int unsigned ROWS  = 4096,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (inc_i)  row_o <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
  end
endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
  import sdram_wr_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LAST_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdram_cmd_e        cmd_d,
  input  logic [BANK_W-1:0] ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [PIX_W-1:0]  dq_d,
  input  logic              oe_d,
  input  logic              last_we_i,
  input  logic [LAST_W-1:0] last_d,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PIX_W-1:0]  dq_o,
  output logic              oe_o,
  output logic [LAST_W-1:0] last_o,
  output logic              last_valid_o
);
  logic [3:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q        <= CMD_NOP;
      ba_o         <= '0;
      addr_o       <= '0;
      dq_o         <= '0;
      oe_o         <= 1'b0;
      last_valid_o <= 1'b0;
      last_o       <= '0;
    end else begin
      cmd_q        <= cmd_d;
      ba_o         <= ba_d;
      addr_o       <= addr_d;
      dq_o         <= dq_d;
      oe_o         <= oe_d;
      last_valid_o <= last_we_i;
      if (last_we_i) last_o <= last_d;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
endmodule

// File: rtl/sdram_line_writer.sv
module sdram_line_writer
  import sdram_wr_pkg::*;
#(
  parameter int unsigned PIX_W       = 8,
  parameter int unsigned LINE_LEN    = 1024,
  parameter int unsigned ROWS        = 4096,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned BANK_SEL    = 0,
  parameter int unsigned REF_PER_GAP = 25,
  parameter int unsigned T_RFC       = 8,
  parameter int unsigned T_RP        = 2,
  parameter int unsigned T_RCD       = 2,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned CAS_LAT     = 2,
  parameter int unsigned INIT_WAIT   = 20000,
  localparam int unsigned ROW_W      = $clog2(ROWS),
  localparam int unsigned COL_W      = $clog2(LINE_LEN),
  localparam int unsigned LAST_W     = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              line_valid_i,
  input  logic [PIX_W-1:0]  pixel_i,
  output logic              sdram_cs_n_o,
  output logic              sdram_ras_n_o,
  output logic              sdram_cas_n_o,
  output logic              sdram_we_n_o,
  output logic [BANK_W-1:0] sdram_ba_o,
  output logic [ADDR_W-1:0] sdram_addr_o,
  output logic [PIX_W-1:0]  sdram_dq_o,
  output logic              sdram_dq_oe_o,
  output logic [LAST_W-1:0] last_addr_o,
  output logic              last_valid_o
);
  localparam int unsigned TMR_MAX = max2(max2(INIT_WAIT, T_RFC),
                                         max2(max2(T_RP, T_RCD), T_MRD));
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned PIX_CW  = COL_W + 1;
  localparam int unsigned REF_CW  = $clog2(max2(REF_PER_GAP, 2) + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'((CAS_LAT << 4) | 7);
  localparam logic [ADDR_W-1:0] PRE_ALL   = ADDR_W'(1 << 10);
  localparam logic [BANK_W-1:0] BANK      = BANK_W'(BANK_SEL);

  wr_state_e         state_q, state_d;
  logic [PIX_CW-1:0] pix_cnt_q;
  logic [REF_CW-1:0] ref_cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic              tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              ref_clr, ref_inc, pix_first, pix_inc, line_done;

  sdram_cmd_e        cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [PIX_W-1:0]  dq_d;
  logic              oe_d;

  sdram_wr_timer #(.CNT_W(TMR_W), .RST_VAL(INIT_WAIT - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  sdram_wr_rowctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .inc_i(line_done), .row_o(row_q)
  );

  sdram_wr_pins #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W),
                  .LAST_W(LAST_W)) u_pins (
    .clk_i, .rst_ni,
    .cmd_d, .ba_d, .addr_d, .dq_d, .oe_d,
    .last_we_i(line_done),
    .last_d({BANK, row_q, COL_W'(LINE_LEN - 1)}),
    .cs_n_o(sdram_cs_n_o), .ras_n_o(sdram_ras_n_o),
    .cas_n_o(sdram_cas_n_o), .we_n_o(sdram_we_n_o),
    .ba_o(sdram_ba_o), .addr_o(sdram_addr_o),
    .dq_o(sdram_dq_o), .oe_o(sdram_dq_oe_o),
    .last_o(last_addr_o), .last_valid_o(last_valid_o)
  );

  always_comb begin
    state_d   = state_q;
    cmd_d     = CMD_NOP;
    ba_d      = '0;
    addr_d    = '0;
    dq_d      = '0;
    oe_d      = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ref_clr   = 1'b0;
    ref_inc   = 1'b0;
    pix_first = 1'b0;
    pix_inc   = 1'b0;
    line_done = 1'b0;
    unique case (state_q)
      ST_INIT: if (tmr_zero) begin
        cmd_d    = CMD_PRE;
        addr_d   = PRE_ALL;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RP - 1);
        ref_clr  = 1'b1;
        state_d  = ST_IREF;
      end
      ST_IREF: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RFC - 1);
        ref_inc  = 1'b1;
        if (ref_cnt_q == REF_CW'(1)) state_d = ST_MRS;
      end
      ST_MRS: if (tmr_zero) begin
        cmd_d    = CMD_MRS;
        addr_d   = MODE_WORD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_MRD - 1);
        state_d  = ST_IDLE;
      end
      ST_IDLE: if (tmr_zero && start_i) begin
        cmd_d    = CMD_ACT;
        ba_d     = BANK;
        addr_d   = ADDR_W'(row_q);
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RCD - 1);
        state_d  = ST_OPEN;
      end
      ST_OPEN: if (tmr_zero && line_valid_i) begin
        cmd_d     = CMD_WR;
        ba_d      = BANK;
        dq_d      = pixel_i;
        oe_d      = 1'b1;
        pix_first = 1'b1;
        state_d   = ST_WRITE;
      end
      ST_WRITE: begin
        if (pix_cnt_q == PIX_CW'(LINE_LEN)) begin
          cmd_d     = CMD_BST;
          line_done = 1'b1;
          state_d   = ST_PRE;
        end else if (line_valid_i) begin
          dq_d    = pixel_i;
          oe_d    = 1'b1;
          pix_inc = 1'b1;
        end
      end
      ST_PRE: begin
        cmd_d    = CMD_PRE;
        ba_d     = BANK;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RP - 1);
        ref_clr  = 1'b1;
        state_d  = ST_REF;
      end
      ST_REF: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RFC - 1);
        ref_inc  = 1'b1;
        if (ref_cnt_q == REF_CW'(REF_PER_GAP - 1)) state_d = ST_ACT;
      end
      ST_ACT: if (tmr_zero) begin
        cmd_d    = CMD_ACT;
        ba_d     = BANK;
        addr_d   = ADDR_W'(row_q);
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RCD - 1);
        state_d  = ST_OPEN;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INIT;
      pix_cnt_q <= '0;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (pix_first)    pix_cnt_q <= PIX_CW'(1);
      else if (pix_inc) pix_cnt_q <= pix_cnt_q + 1'b1;
      if (ref_clr)      ref_cnt_q <= '0;
      else if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_wr_chk.sv
module sdram_wr_chk
  import sdram_wr_pkg::*;
#(
  parameter int unsigned ROWS   = 4096,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input wr_state_e         state_i,
  input logic              tmr_zero_i,
  input logic              line_valid_i,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              oe_i,
  input logic              last_valid_i
);
  logic [3:0] cmd;
  assign cmd = {cs_n_i, ras_n_i, cas_n_i, we_n_i};

  assert_strobe_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i |-> ((state_i == ST_OPEN) && tmr_zero_i) || (state_i == ST_WRITE));

  assert_write_has_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_WR) |-> oe_i);

  assert_oe_only_in_burst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> (cmd == CMD_WR) || (cmd == CMD_NOP));

  assert_stop_then_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_BST) |=> (cmd == CMD_PRE));

  assert_report_with_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_valid_i |-> (cmd == CMD_BST));

  assert_refresh_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  assert_row_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> (addr_i < ADDR_W'(ROWS)));
endmodule

bind sdram_line_writer sdram_wr_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .tmr_zero_i   (tmr_zero),
  .line_valid_i (line_valid_i),
  .cs_n_i       (sdram_cs_n_o),
  .ras_n_i      (sdram_ras_n_o),
  .cas_n_i      (sdram_cas_n_o),
  .we_n_i       (sdram_we_n_o),
  .addr_i       (sdram_addr_o),
  .oe_i         (sdram_dq_oe_o),
  .last_valid_i (last_valid_o)
);

// File: tb/tb_sdram_line_writer.sv
module tb_sdram_line_writer;
  localparam int L = 16, NROW = 4, W = 10, TRP = 2, TRFC = 4, TMRD = 2;
  localparam int TRCD = 2, NREF = 3, BANK = 1, CL = 2;
  localparam int RW = 2, CW = 4;
  localparam int C_NOP = 7, C_ACT = 3, C_WR = 4, C_BST = 6, C_PRE = 2;
  localparam int C_REF = 1, C_MRS = 0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0, start_i = 1'b0, line_valid_i = 1'b0;
  logic [7:0] pixel_i = '0;
  logic cs_n, ras_n, cas_n, we_n, oe, last_valid;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [7:0] dq;
  logic [RW+CW+1:0] last_addr;

  sdram_line_writer #(
    .PIX_W(8), .LINE_LEN(L), .ROWS(NROW), .ADDR_W(12), .BANK_W(2),
    .BANK_SEL(BANK), .REF_PER_GAP(NREF), .T_RFC(TRFC), .T_RP(TRP),
    .T_RCD(TRCD), .T_MRD(TMRD), .CAS_LAT(CL), .INIT_WAIT(W)
  ) dut (
    .clk_i(clk), .rst_ni, .start_i, .line_valid_i, .pixel_i,
    .sdram_cs_n_o(cs_n), .sdram_ras_n_o(ras_n), .sdram_cas_n_o(cas_n),
    .sdram_we_n_o(we_n), .sdram_ba_o(ba), .sdram_addr_o(addr),
    .sdram_dq_o(dq), .sdram_dq_oe_o(oe),
    .last_addr_o(last_addr), .last_valid_o(last_valid)
  );

  int cyc = 0;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int exp_cmd[int];
  int exp_addr[int];
  int exp_ba[int];
  string exp_tag[int];
  int exp_dq[int];
  int exp_last[int];
  int cur_last = 0;

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, cyc, act, expv);
    end
  endtask

  task automatic put(int n, int c, int a, int b, string t);
    exp_cmd[n] = c; exp_addr[n] = a; exp_ba[n] = b; exp_tag[n] = t;
  endtask

  function automatic int pix(int li, int j);
    return (li * 37 + j * 5 + 1) & 255;
  endfunction

  // reference model: every output compared on every falling edge
  always @(negedge clk) begin
    int ec, ea, eb;
    string t;
    if (rst_ni && cyc > 0 && !done) begin
      ec = exp_cmd.exists(cyc) ? exp_cmd[cyc] : C_NOP;
      ea = exp_addr.exists(cyc) ? exp_addr[cyc] : 0;
      eb = exp_ba.exists(cyc) ? exp_ba[cyc] : 0;
      t  = exp_tag.exists(cyc) ? exp_tag[cyc] : "R10";
      chk(t, "cmd", int'({cs_n, ras_n, cas_n, we_n}), ec);
      chk(t, "addr", int'(addr), ea);
      chk(t, "bank", int'(ba), eb);
      if (exp_dq.exists(cyc)) begin
        chk("R4", "dq_oe", int'(oe), 1);
        chk("R4", "dq", int'(dq), exp_dq[cyc]);
      end else begin
        chk("R10", "dq_oe", int'(oe), 0);
      end
      if (exp_last.exists(cyc)) begin
        cur_last = exp_last[cyc];
        chk("R9", "last_valid", int'(last_valid), 1);
      end else begin
        chk("R9", "last_valid", int'(last_valid), 0);
      end
      chk("R9", "last_addr", int'(last_addr), cur_last);
    end
  end

  task automatic at_edge(int n);
    while (cyc < n - 1) @(negedge clk);
  endtask

  task automatic expect_line(int f, int row, int li);
    int a, nrow;
    put(f, C_WR, 0, BANK, "R4");
    for (int j = 0; j < L; j++) exp_dq[f + j] = pix(li, j);
    put(f + L, C_BST, 0, 0, "R5");
    exp_last[f + L] = (BANK << (RW + CW)) | (row << CW) | (L - 1);
    put(f + L + 1, C_PRE, 0, BANK, "R5");
    for (int k = 0; k < NREF; k++) put(f + L + 1 + TRP + k * TRFC, C_REF, 0, 0, "R6");
    a = f + L + 1 + TRP + NREF * TRFC;
    nrow = (row + 1) % NROW;
    put(a, C_ACT, nrow, BANK, (row == NROW - 1) ? "R8" : "R7");
  endtask

  task automatic drive_line(int f, int li);
    at_edge(f);
    for (int j = 0; j < L; j++) begin
      line_valid_i = 1'b1;
      pixel_i = 8'(pix(li, j));
      @(negedge clk);
    end
    line_valid_i = 1'b0;
    pixel_i = '0;
  endtask

  initial begin
    int f;
    int gaps[6];
    gaps = '{33, 40, 33, 45, 33, 0};
    put(1, C_NOP, 0, 0, "R1");
    put(W - 1, C_NOP, 0, 0, "R1");
    put(W, C_PRE, 'h400, 0, "R2");
    put(W + TRP, C_REF, 0, 0, "R2");
    put(W + TRP + TRFC, C_REF, 0, 0, "R2");
    put(W + TRP + 2 * TRFC, C_MRS, (CL << 4) | 7, 0, "R2");
    put(8, C_NOP, 0, 0, "R3");
    put(30, C_ACT, 0, BANK, "R3");
    put(31, C_NOP, 0, 0, "R3");

    repeat (3) @(negedge clk);
    chk("R1", "reset cmd", int'({cs_n, ras_n, cas_n, we_n}), C_NOP);
    chk("R1", "reset addr", int'(addr), 0);
    chk("R1", "reset dq_oe", int'(oe), 0);
    chk("R1", "reset last_valid", int'(last_valid), 0);
    rst_ni = 1'b1;

    at_edge(8);               // early start, before init completes
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    at_edge(30);              // accepted start, then a repeated one
    start_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;

    f = 30 + TRCD;
    for (int li = 0; li < 6; li++) begin
      expect_line(f, li % NROW, li);
      drive_line(f, li);
      f += gaps[li];
    end
    at_edge(cyc + 45);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule